// File: doc/BRIEF.md
# SDIO Extended I/O Command Frame Generator

This block forms the 48-bit command token that a host sends on the SDIO command line to start a multi-byte or multi-block I/O register transfer (command index 53). The caller gives the transfer parameters directly: direction, function number, byte or block mode, fixed or incrementing address, a 17-bit start address, and a 10-bit transfer size. The size is a byte length in byte mode and a block count in block mode. The block turns these into the 32-bit command argument, handling the special codes on its own. It then appends a 7-bit CRC and shifts the whole token out most significant bit first.

A one-cycle `start` pulse loads a request while the block is idle. The frame then advances by one bit on every cycle in which `bit_en` is high, so the caller sets the bus bit rate through that enable. `busy` stays high while the line is driven, and `done` pulses once when the token has been fully sent. A request whose size cannot be encoded is refused: it raises a one-cycle `param_err` and sends nothing. The card's response and the data phase are handled elsewhere.

Top module: `sdio_xcmd_gen`

## Requirements
- R1: After reset and whenever idle, `cmd_line` is 1 and `cmd_line_oe` is 0. After reset, `busy`, `done` and `param_err` are 0.
- R2: The frame is 48 bits sent MSB first. From the first bit sent, the fields are:
  - a 0 start bit
  - a 1 direction bit
  - the 6-bit index 110101 (0x35)
  - the 32-bit argument
  - the 7-bit CRC
  - a 1 end bit
- R3: The argument fields are:
  - bit 31 = `wr_dir` (1 = write to card)
  - bits 30..28 = `func_sel`
  - bit 27 = `blk_mode`
  - bit 26 = `addr_incr`
  - bits 25..9 = `reg_addr`
  - bits 8..0 = the encoded count
- R4: In byte mode (`blk_mode`=0), lengths 1..511 are encoded directly in bits 8..0, and length 512 is encoded as count 0.
- R5: In block mode (`blk_mode`=1), block counts 0..511 are encoded directly. Count 0 (open-ended transfer) is a legal request and is sent as 0.
- R6: A read of function 2 in block mode, with incrementing address, address 0x08000 and 1 block, produces the argument 0x2D000001.
- R7: The CRC field is the remainder of the first 40 frame bits under generator x^7+x^3+1 with zero initial value, MSB first.
- R8: Each frame bit stays on the line until a clock edge with `bit_en`=1 advances it. Exactly 48 bits are sent per accepted request.
- R9: A `start` while `busy` is 1 is ignored. The frame in progress is unchanged and no second frame follows.
- R10: On the clock edge with `bit_en`=1 that consumes the end bit, `busy` and `cmd_line_oe` fall together and `done` rises for exactly one cycle.
- R11: A `start` while idle is refused in three cases: byte mode with length 0, byte mode with length above 512, or block mode with count above 511. In these cases `param_err` pulses for one cycle, `busy` stays 0 and no frame is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance the line by one bit on this edge |
| start | input | 1 | Request pulse, taken only while idle |
| wr_dir | input | 1 | 1 = write to card, 0 = read |
| func_sel | input | 3 | I/O function number |
| blk_mode | input | 1 | 1 = block count, 0 = byte length |
| addr_incr | input | 1 | 1 = incrementing address, 0 = fixed |
| reg_addr | input | 17 | Start register address |
| xfer_len | input | 10 | Byte length (1..512) or block count (0..511) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the end bit |
| param_err | output | 1 | One-cycle pulse for a refused request |
| cmd_line | output | 1 | Serial command data |
| cmd_line_oe | output | 1 | Output enable for the command line |

## Verification
A new request can arrive in the same cycle that the serializer is shifting an existing frame. The bench provokes this by pulsing `start` with different parameters partway through a frame, while `bit_en` toggles at random. The captured 48-bit token must still match the original request, and `busy` must stay low after `done`. The other overlap is the final enabled edge, where the serializer drops the line and raises `done` in the same cycle. The bench judges this by checking `done` on the first sample after the 48th bit is taken, and checking that `busy` has fallen by then.

// File: rtl/sdio_xcmd_pkg.sv
package sdio_xcmd_pkg;

    localparam int FN_W      = 3;
    localparam int ADDR_W    = 17;
    localparam int CNT_W     = 9;
    localparam int LEN_W     = CNT_W + 1;
    localparam int IDX_W     = 6;
    localparam int ARG_W     = 32;
    localparam int CRC_W     = 7;
    localparam int BODY_W    = 2 + IDX_W + ARG_W;
    localparam int FRAME_W   = BODY_W + CRC_W + 1;
    localparam int MAX_BYTES = 1 << CNT_W;
    localparam int MAX_BLKS  = MAX_BYTES - 1;

    localparam logic [IDX_W-1:0] XCMD_INDEX = 6'h35;
    // feedback taps of x^7 + x^3 + 1 without the leading term
    localparam logic [CRC_W-1:0] CRC_TAPS   = 7'h09;

    typedef struct packed {
        logic              write;
        logic [FN_W-1:0]   func;
        logic              block;
        logic              incr;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } xfer_req_t;

    // field order is the on-wire order of the argument, MSB first
    typedef struct packed {
        logic              write;
        logic [FN_W-1:0]   func;
        logic              block;
        logic              incr;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
    } xcmd_arg_t;

    typedef struct packed {
        logic              start_b;
        logic              dir_b;
        logic [IDX_W-1:0]  index;
        xcmd_arg_t         arg;
        logic [CRC_W-1:0]  crc;
        logic              end_b;
    } xcmd_frame_t;

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] acc,
                                                   input logic din);
        logic fb;
        fb = acc[CRC_W-1] ^ din;
        return {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
    endfunction

endpackage

// File: rtl/xcmd_arg_pack.sv
module xcmd_arg_pack
    import sdio_xcmd_pkg::*;
(
    input  xfer_req_t req,
    output xcmd_arg_t arg,
    output logic      bad
);
    localparam logic [LEN_W-1:0] BYTE_LIMIT = LEN_W'(MAX_BYTES);
    localparam logic [LEN_W-1:0] BLK_LIMIT  = LEN_W'(MAX_BLKS);

    always_comb begin
        if (req.block) begin
            bad = (req.len > BLK_LIMIT);
        end else begin
            bad = (req.len == '0) || (req.len > BYTE_LIMIT);
        end

        arg.write = req.write;
        arg.func  = req.func;
        arg.block = req.block;
        arg.incr  = req.incr;
        arg.addr  = req.addr;
        // full-size byte transfer has no room in the count field: code 0
        if (!req.block && (req.len == BYTE_LIMIT)) begin
            arg.count = '0;
        end else begin
            arg.count = req.len[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/xcmd_crc7.sv
module xcmd_crc7
    import sdio_xcmd_pkg::*;
#(
    parameter int DATA_W = BODY_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            acc = crc7_step(acc, data[i]);
        end
    end

    assign crc = acc;
endmodule

// File: rtl/xcmd_serializer.sv
module xcmd_serializer #(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               bit_en,
    output logic               busy,
    output logic               done,
    output logic               line,
    output logic               line_oe
);
    localparam int               PTR_W = $clog2(FRAME_W);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [PTR_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            left  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (load) begin
                    shreg <= frame;
                    left  <= LAST;
                    busy  <= 1'b1;
                end
            end else if (bit_en) begin
                if (left == '0) begin
                    shreg <= '1;
                    busy  <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    shreg <= {shreg[FRAME_W-2:0], 1'b1};
                    left  <= left - 1'b1;
                end
            end
        end
    end

    assign line    = busy ? shreg[FRAME_W-1] : 1'b1;
    assign line_oe = busy;
endmodule

// File: rtl/sdio_xcmd_gen.sv
module sdio_xcmd_gen
    import sdio_xcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              start,
    input  logic              wr_dir,
    input  logic [FN_W-1:0]   func_sel,
    input  logic              blk_mode,
    input  logic              addr_incr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              busy,
    output logic              done,
    output logic              param_err,
    output logic              cmd_line,
    output logic              cmd_line_oe
);
    xfer_req_t           req;
    xcmd_arg_t           arg;
    xcmd_frame_t         frame;
    logic                req_bad;
    logic [BODY_W-1:0]   body;
    logic [CRC_W-1:0]    crc;
    logic                accept;
    logic                reject;

    assign req.write = wr_dir;
    assign req.func  = func_sel;
    assign req.block = blk_mode;
    assign req.incr  = addr_incr;
    assign req.addr  = reg_addr;
    assign req.len   = xfer_len;

    xcmd_arg_pack u_pack (
        .req (req),
        .arg (arg),
        .bad (req_bad)
    );

    assign body = {1'b0, 1'b1, XCMD_INDEX, arg};

    xcmd_crc7 #(.DATA_W(BODY_W)) u_crc (
        .data (body),
        .crc  (crc)
    );

    always_comb begin
        frame.start_b = 1'b0;
        frame.dir_b   = 1'b1;
        frame.index   = XCMD_INDEX;
        frame.arg     = arg;
        frame.crc     = crc;
        frame.end_b   = 1'b1;
    end

    assign accept = start && !busy && !req_bad;
    assign reject = start && !busy && req_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            param_err <= 1'b0;
        end else begin
            param_err <= reject;
        end
    end

    xcmd_serializer #(.FRAME_W(FRAME_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .frame   (frame),
        .bit_en  (bit_en),
        .busy    (busy),
        .done    (done),
        .line    (cmd_line),
        .line_oe (cmd_line_oe)
    );
endmodule

// File: rtl/sdio_xcmd_chk.sv
module sdio_xcmd_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic start,
    input logic busy,
    input logic done,
    input logic param_err,
    input logic cmd_line,
    input logic cmd_line_oe
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !cmd_line_oe |-> cmd_line);

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_line_oe) |-> !cmd_line);

    p_end_bit_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_line_oe) |-> $past(cmd_line));

    p_hold_bit_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_line_oe && !bit_en |=> cmd_line_oe && $stable(cmd_line));

    p_busy_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        busy && start && !bit_en |=> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_at_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done && !cmd_line_oe);

    p_err_no_frame_r11: assert property (@(posedge clk) disable iff (rst)
        param_err |-> !busy && !cmd_line_oe && !done);
endmodule

bind sdio_xcmd_gen sdio_xcmd_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .param_err   (param_err),
    .cmd_line    (cmd_line),
    .cmd_line_oe (cmd_line_oe)
);

// File: tb/sdio_xcmd_gen_tb.sv
`timescale 1ns/1ps
module sdio_xcmd_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en;
    logic        start;
    logic        wr_dir;
    logic [2:0]  func_sel;
    logic        blk_mode;
    logic        addr_incr;
    logic [16:0] reg_addr;
    logic [9:0]  xfer_len;
    logic        busy;
    logic        done;
    logic        param_err;
    logic        cmd_line;
    logic        cmd_line_oe;

    int n_vec = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #2.5 clk = ~clk;

    sdio_xcmd_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .start       (start),
        .wr_dir      (wr_dir),
        .func_sel    (func_sel),
        .blk_mode    (blk_mode),
        .addr_incr   (addr_incr),
        .reg_addr    (reg_addr),
        .xfer_len    (xfer_len),
        .busy        (busy),
        .done        (done),
        .param_err   (param_err),
        .cmd_line    (cmd_line),
        .cmd_line_oe (cmd_line_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_arg(input logic w, input logic [2:0] fn,
                                            input logic blk, input logic inc,
                                            input logic [16:0] addr, input logic [9:0] len);
        logic [31:0] cnt;
        if (!blk && len == 10'd512) cnt = 32'd0;
        else cnt = {23'd0, len[8:0]};
        return (32'(w) << 31) | (32'(fn) << 28) | (32'(blk) << 27) |
               (32'(inc) << 26) | (32'(addr) << 9) | cnt;
    endfunction

    // polynomial long division of msg * x^7 by x^7 + x^3 + 1
    function automatic logic [6:0] ref_crc(input logic [39:0] msg);
        logic [46:0] r;
        r = {msg, 7'd0};
        for (int i = 46; i >= 7; i--) begin
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        end
        return r[6:0];
    endfunction

    task automatic run_frame(input logic w, input logic [2:0] fn, input logic blk,
                             input logic inc, input logic [16:0] addr,
                             input logic [9:0] len, input int en_pct,
                             input bit poke, input string arg_tag);
        logic [31:0] e_arg;
        logic [39:0] e_body;
        logic [47:0] e_frame;
        logic [47:0] got;
        int          nbits;
        int          cyc;
        bit          fin;
        e_arg   = ref_arg(w, fn, blk, inc, addr, len);
        e_body  = {2'b01, 6'h35, e_arg};
        e_frame = {e_body, ref_crc(e_body), 1'b1};
        got     = '0;
        nbits   = 0;
        cyc     = 0;
        fin     = 0;

        @(negedge clk);
        wr_dir = w; func_sel = fn; blk_mode = blk; addr_incr = inc;
        reg_addr = addr; xfer_len = len; start = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 4000) begin
            if (nbits == 48) begin
                // R10: done must be up right after the edge taking the end bit
                chk(done == 1'b1, "R10", "done after end bit", 64'(done), 64'd1);
                chk(busy == 1'b0 && cmd_line_oe == 1'b0, "R10", "busy/oe fall with done",
                    64'({busy, cmd_line_oe}), 64'd0);
                fin = 1;
            end else begin
                if (poke && cyc == 3) begin
                    start = 1'b1; reg_addr = ~addr; func_sel = ~fn; xfer_len = 10'd7;
                end else begin
                    start = 1'b0;
                end
                bit_en = (($urandom % 100) < 32'(en_pct));
                if (cmd_line_oe && bit_en) begin
                    got = {got[46:0], cmd_line};
                    nbits++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        chk(nbits == 48, "R8", "bits sent", 64'(nbits), 64'd48);
        chk(got[47:40] == 8'b01_110101 && got[0] == 1'b1, "R2", "framing bits",
            64'({got[47:40], got[0]}), 64'({8'b01_110101, 1'b1}));
        chk(got[39:8] == e_arg, arg_tag, "argument", 64'(got[39:8]), 64'(e_arg));
        chk(got[7:1] == e_frame[7:1], "R7", "crc7", 64'(got[7:1]), 64'(e_frame[7:1]));
        if (poke) begin
            chk(got == e_frame, "R9", "frame unchanged by start while busy",
                64'(got), 64'(e_frame));
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", 64'(done), 64'd0);
        if (poke) begin
            @(negedge clk);
            chk(busy == 1'b0 && cmd_line_oe == 1'b0, "R9", "no second frame",
                64'(busy), 64'd0);
        end
    endtask

    task automatic run_bad(input logic blk, input logic [9:0] len);
        @(negedge clk);
        wr_dir = 1'b1; func_sel = 3'd1; blk_mode = blk; addr_incr = 1'b1;
        reg_addr = 17'h00123; xfer_len = len; start = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(param_err == 1'b1, "R11", "param_err raised", 64'(param_err), 64'd1);
        chk(busy == 1'b0 && cmd_line_oe == 1'b0 && cmd_line == 1'b1, "R11", "no frame",
            64'({busy, cmd_line_oe, cmd_line}), 64'b001);
        @(negedge clk);
        chk(param_err == 1'b0 && busy == 1'b0, "R11", "param_err one cycle",
            64'({param_err, busy}), 64'd0);
    endtask

    initial begin
        while (cyc_total < 150000) begin
            @(posedge clk);
            cyc_total++;
        end
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D1A));
        rst = 1'b1; bit_en = 1'b0; start = 1'b0; wr_dir = 1'b0; func_sel = '0;
        blk_mode = 1'b0; addr_incr = 1'b0; reg_addr = '0; xfer_len = 10'd1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_line == 1'b1 && cmd_line_oe == 1'b0, "R1", "idle line",
            64'({cmd_line, cmd_line_oe}), 64'b10);
        chk(busy == 1'b0 && done == 1'b0 && param_err == 1'b0, "R1", "idle flags",
            64'({busy, done, param_err}), 64'd0);

        // R6 reference argument
        run_frame(1'b0, 3'd2, 1'b1, 1'b1, 17'h08000, 10'd1, 100, 0, "R6");
        chk(ref_arg(1'b0, 3'd2, 1'b1, 1'b1, 17'h08000, 10'd1) == 32'h2D000001, "R6",
            "bench model", 64'(ref_arg(1'b0, 3'd2, 1'b1, 1'b1, 17'h08000, 10'd1)),
            64'h2D000001);
        // R4 byte mode lengths
        run_frame(1'b1, 3'd1, 1'b0, 1'b0, 17'h1FFFF, 10'd512, 100, 0, "R4");
        run_frame(1'b0, 3'd2, 1'b0, 1'b1, 17'h00000, 10'd1, 60, 0, "R4");
        run_frame(1'b1, 3'd7, 1'b0, 1'b1, 17'h0A5A5, 10'd511, 100, 0, "R4");
        // R5 block counts, including open-ended 0
        run_frame(1'b0, 3'd2, 1'b1, 1'b0, 17'h00010, 10'd0, 100, 0, "R5");
        run_frame(1'b1, 3'd3, 1'b1, 1'b1, 17'h15555, 10'd511, 80, 0, "R5");
        // R8 sparse bit enable
        run_frame(1'b1, 3'd5, 1'b0, 1'b0, 17'h0C3C3, 10'd64, 25, 0, "R8");
        // R9 start while busy
        run_frame(1'b0, 3'd4, 1'b1, 1'b1, 17'h01234, 10'd9, 50, 1, "R9");
        run_frame(1'b1, 3'd6, 1'b0, 1'b0, 17'h1ABCD, 10'd300, 100, 1, "R9");
        // R11 refused requests
        run_bad(1'b0, 10'd0);
        run_bad(1'b0, 10'd513);
        run_bad(1'b1, 10'd512);
        run_bad(1'b0, 10'd1023);

        // R3 random requests
        for (int k = 0; k < 40; k++) begin
            logic        rb;
            logic [9:0]  rl;
            rb = 1'(($urandom % 2));
            if (rb) rl = 10'($urandom % 512);
            else rl = 10'(($urandom % 512) + 1);
            run_frame(1'($urandom % 2), 3'($urandom % 8), rb, 1'($urandom % 2),
                      17'($urandom), rl, 20 + int'($urandom % 81), (k % 7) == 3, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule